// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device side of a two-port, byte-wide host interface. The host sees a data port and a combined control port. Reading the control port returns status. Writing it issues a command. Every access is a single-cycle strobe, either `host_wr` or `host_rd`, with a small offset. Two status flags pace the host. The input flag (IBF) tells the host that a byte it wrote is still waiting to be taken. The output flag (OBF) tells the host that a result byte is waiting to be read.

A sequencer turns each host command sequence into one access to a 256-entry, byte-wide register space. That space is reached through a plain address / write-data / write-enable port, with read data returned combinationally, so any register bank can be attached.

- For a read, the host writes command 0x80, then a register address. The sequencer fetches that register into the output buffer and raises OBF.
- For a write, the host writes command 0x81, then an address, then a data byte. The sequencer issues one write strobe.

The sequencer has four states:

- IDLE waits for a command.
- RD_ADDR waits for the read address.
- WR_ADDR waits for the write address.
- WR_DATA waits for the write data.

The transitions are:

- Command 0x80 goes to RD_ADDR from any state.
- Command 0x81 goes to WR_ADDR from any state.
- Any other command goes to IDLE.
- A data byte in RD_ADDR loads the output buffer and returns to IDLE.
- A data byte in WR_ADDR stores the address and goes to WR_DATA.
- A data byte in WR_DATA strobes the write and returns to IDLE.
- A data byte in IDLE is discarded.

Top module: `ec_host_port`

## Requirements
- R1: A host read at offset 4 returns status, with bit 1 = IBF, bit 0 = OBF and bits 7:2 = 0. Both flags are 0 after reset. A read at any offset other than 0 and 4 returns 0. A write at any offset other than 0 and 4 is ignored and does not set IBF. While `host_rd` is low, `host_rdata` is 0.
- R2: A host write to offset 0 (data) or offset 4 (command) is accepted only while IBF is clear. The accepting edge sets IBF, and IBF clears on the following edge, when the sequencer consumes the byte.
- R3: A host write that arrives while IBF is set is dropped, and the sequence continues as if that write had not happened.
- R4: After command 0x80, the next accepted data byte is a register address. On the edge that consumes it, the addressed register value is loaded into the output buffer and OBF is set.
- R5: A host read of offset 0 returns the output buffer and clears OBF on that edge.
- R6: After command 0x81, the first accepted data byte is the address and the second is the data. On the cycle after the data byte is accepted, `reg_we` is high for exactly one cycle, with that address on `reg_addr` and that data on `reg_wdata`.
- R7: A command byte other than 0x80 or 0x81 returns the sequencer to IDLE. Data bytes received in IDLE cause no register access and do not set OBF.
- R8: A command written in the middle of a sequence abandons that sequence, with no register write, and starts the new command.
- R9: When a result is loaded in the same cycle as a host read of offset 0, OBF stays set, and the new result is what the next read returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Host port offset: 0 selects data, 4 selects status/command |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| reg_addr | output | 8 | Register space address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Register write strobe, one cycle |
| reg_rdata | input | 8 | Register read data, combinational from `reg_addr` |

## Verification
Loading a fetched register into the output buffer and the host draining the data port can land on the same clock edge.

The bench provokes this as follows. It leaves a first read result unread, then issues a second read command. It pulses the host data-port read in exactly the cycle in which the sequencer consumes the second address. The read in that cycle must return the old byte. Afterwards, status must still show OBF set, and the next data read must return the newly fetched register.

A second overlap, a host write landing while IBF is still set, is judged by the register write it must not corrupt.

// File: rtl/ec_host_pkg.sv
`timescale 1ns/1ps
package ec_host_pkg;
    localparam int DW      = 8;
    localparam int PORT_W  = 3;
    localparam logic [PORT_W-1:0] PORT_DATA = 3'd0;
    localparam logic [PORT_W-1:0] PORT_CTRL = 3'd4;
    localparam logic [DW-1:0] CMD_RD = 8'h80;
    localparam logic [DW-1:0] CMD_WR = 8'h81;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_RD_ADDR = 2'd1,
        S_WR_ADDR = 2'd2,
        S_WR_DATA = 2'd3
    } seq_state_t;
endpackage

// File: rtl/ec_host_inlatch.sv
`timescale 1ns/1ps
module ec_host_inlatch
    import ec_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [DW-1:0]     host_wdata,
    output logic              ibf,
    output logic [DW-1:0]     byte_q,
    output logic              is_cmd_q
);
    logic sel_data, sel_ctrl, accept;

    assign sel_data = (host_addr == PORT_DATA);
    assign sel_ctrl = (host_addr == PORT_CTRL);
    assign accept   = host_wr && (sel_data || sel_ctrl) && !ibf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ibf      <= 1'b0;
            byte_q   <= '0;
            is_cmd_q <= 1'b0;
        end else begin
            ibf <= accept;
            if (accept) begin
                byte_q   <= host_wdata;
                is_cmd_q <= sel_ctrl;
            end
        end
    end

    p_ibf_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ibf |=> !ibf);
    p_drop_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && ibf) |=> $stable(byte_q) && $stable(is_cmd_q));
    p_foreign_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr != PORT_DATA && host_addr != PORT_CTRL) |=> !ibf);
endmodule

// File: rtl/ec_host_seq.sv
`timescale 1ns/1ps
module ec_host_seq
    import ec_host_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ibf,
    input  logic [DW-1:0]     byte_q,
    input  logic              is_cmd_q,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DW-1:0]     reg_wdata,
    output logic              reg_we,
    output logic              load
);
    seq_state_t        st, st_nxt;
    logic [REG_AW-1:0] addr_q;
    logic              take_data;

    assign take_data = ibf && !is_cmd_q;

    // next-state decision
    always_comb begin
        st_nxt = st;
        if (ibf) begin
            if (is_cmd_q) begin
                case (byte_q)
                    CMD_RD:  st_nxt = S_RD_ADDR;
                    CMD_WR:  st_nxt = S_WR_ADDR;
                    default: st_nxt = S_IDLE;
                endcase
            end else begin
                unique case (st)
                    S_IDLE:    st_nxt = S_IDLE;
                    S_RD_ADDR: st_nxt = S_IDLE;
                    S_WR_ADDR: st_nxt = S_WR_DATA;
                    S_WR_DATA: st_nxt = S_IDLE;
                endcase
            end
        end
    end

    // state register and captured write address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            addr_q <= '0;
        end else begin
            st <= st_nxt;
            if (take_data && st == S_WR_ADDR)
                addr_q <= byte_q[REG_AW-1:0];
        end
    end

    // outputs per state
    always_comb begin
        reg_addr  = addr_q;
        reg_wdata = byte_q;
        reg_we    = 1'b0;
        load      = 1'b0;
        unique case (st)
            S_RD_ADDR: if (take_data) begin
                reg_addr = byte_q[REG_AW-1:0];
                load     = 1'b1;
            end
            S_WR_DATA: if (take_data) reg_we = 1'b1;
            S_IDLE, S_WR_ADDR: ;
        endcase
    end

    p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    p_no_we_after_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && is_cmd_q) |=> !reg_we);
    p_load_from_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (ibf && !is_cmd_q && !reg_we));
endmodule

// File: rtl/ec_host_outbuf.sv
`timescale 1ns/1ps
module ec_host_outbuf
    import ec_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              ibf,
    input  logic              load,
    input  logic [DW-1:0]     load_data,
    output logic              obf,
    output logic [DW-1:0]     host_rdata
);
    logic [DW-1:0] out_q;
    logic          drain;

    assign drain = host_rd && (host_addr == PORT_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            obf   <= 1'b0;
        end else if (load) begin
            out_q <= load_data;
            obf   <= 1'b1;
        end else if (drain) begin
            obf <= 1'b0;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            if (host_addr == PORT_DATA)
                host_rdata = out_q;
            else if (host_addr == PORT_CTRL)
                host_rdata = {{(DW-2){1'b0}}, ibf, obf};
        end
    end

    p_load_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> obf);
    p_drain_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !load) |=> !obf);
    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && load) |=> obf);
    p_status_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == PORT_CTRL) |-> host_rdata[DW-1:2] == '0);
endmodule

// File: rtl/ec_host_port.sv
`timescale 1ns/1ps
module ec_host_port
    import ec_host_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [REG_AW-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              reg_we,
    input  logic [7:0]        reg_rdata
);
    logic          ibf, is_cmd_q, load, obf;
    logic [DW-1:0] byte_q;

    ec_host_inlatch u_inlatch (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .ibf(ibf), .byte_q(byte_q), .is_cmd_q(is_cmd_q)
    );

    ec_host_seq #(.REG_AW(REG_AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ibf(ibf), .byte_q(byte_q), .is_cmd_q(is_cmd_q),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .load(load)
    );

    ec_host_outbuf u_outbuf (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .ibf(ibf), .load(load), .load_data(reg_rdata), .obf(obf),
        .host_rdata(host_rdata)
    );

    p_we_follows_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(host_wr));
endmodule

// File: tb/ec_host_port_bench.sv
`timescale 1ns/1ps
module ec_host_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we;

    logic [7:0]  mem [256];
    logic [7:0]  shadow [256];
    logic [15:0] exp_q [$];
    int n_chk = 0, n_bad = 0, n_we = 0;

    always #5 clk = ~clk;

    ec_host_port u_ec_host_port (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 8'(i) ^ 8'h5A;
            shadow[i] = 8'(i) ^ 8'h5A;
        end
    end

    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor for register writes
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            n_we++;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R6: actual write %h=%h expected none", reg_addr, reg_wdata);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if ({reg_addr, reg_wdata} !== e) begin
                    n_bad++;
                    $display("FAIL R6: actual %h expected %h", {reg_addr, reg_wdata}, e);
                end
            end
        end
    end

    // all tasks start and end at a falling edge
    task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [7:0] d);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic wait_ibf();
        logic [7:0] s;
        hread(3'd4, s);
        while (s[1]) hread(3'd4, s);
    endtask

    task automatic ec_write(input logic [7:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
        shadow[a] = d;
        wait_ibf(); hwrite(3'd4, 8'h81);
        wait_ibf(); hwrite(3'd0, a);
        wait_ibf(); hwrite(3'd0, d);
        wait_ibf(); idle();
    endtask

    task automatic ec_read(input logic [7:0] a, output logic [7:0] d);
        logic [7:0] s;
        wait_ibf(); hwrite(3'd4, 8'h80);
        wait_ibf(); hwrite(3'd0, a);
        hread(3'd4, s);
        while (!s[0]) hread(3'd4, s);
        hread(3'd0, d);
    endtask

    task automatic run_all();
        logic [7:0] v, s;
        int we0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        hread(3'd4, s); check("R1 reset status", s, 8'h00);
        check("R1 rdata idle", host_rdata, 8'h00);
        // R2 IBF pulse
        hwrite(3'd4, 8'h80);
        hread(3'd4, s); check("R2 ibf set", s, 8'h02);
        hread(3'd4, s); check("R2 ibf cleared", s, 8'h00);
        // R4 OBF timing
        hwrite(3'd0, 8'h07);
        hread(3'd4, s); check("R4 obf not yet", s, 8'h02);
        hread(3'd4, s); check("R4 obf set", s, 8'h01);
        // R5 read then cleared
        hread(3'd0, v); check("R5 data", v, shadow[8'h07]);
        hread(3'd4, s); check("R5 obf cleared", s, 8'h00);
        // R6 writes with readback, boundary addresses
        ec_write(8'h10, 8'hA5);
        ec_write(8'hFF, 8'h3C);
        ec_write(8'h00, 8'hC3);
        ec_read(8'h10, v); check("R6 readback 10", v, 8'hA5);
        ec_read(8'hFF, v); check("R6 readback FF", v, 8'h3C);
        ec_read(8'h00, v); check("R6 readback 00", v, 8'hC3);
        // R3 write while IBF set is dropped
        exp_q.push_back({8'h20, 8'h33}); shadow[8'h20] = 8'h33;
        hwrite(3'd4, 8'h81);
        hwrite(3'd0, 8'h11);
        idle(); hwrite(3'd0, 8'h20);
        idle(); hwrite(3'd0, 8'h33);
        idle(); idle();
        ec_read(8'h20, v); check("R3 dropped byte", v, 8'h33);
        ec_read(8'h11, v); check("R3 untouched", v, shadow[8'h11]);
        // R7 unknown command, then data in idle
        we0 = n_we;
        hwrite(3'd4, 8'h55); idle();
        hwrite(3'd0, 8'h40); idle();
        hwrite(3'd0, 8'h41); idle(); idle();
        hread(3'd4, s); check("R7 no obf", s, 8'h00);
        check("R7 no write", 8'(n_we - we0), 8'h00);
        // R8 abort write by read command
        we0 = n_we;
        hwrite(3'd4, 8'h81); idle();
        hwrite(3'd0, 8'h30); idle();
        hwrite(3'd4, 8'h80); idle();
        hwrite(3'd0, 8'h31); idle();
        hread(3'd4, s); check("R8 obf", s, 8'h01);
        hread(3'd0, v); check("R8 new read", v, shadow[8'h31]);
        check("R8 no write", 8'(n_we - we0), 8'h00);
        // R1 foreign offsets
        hwrite(3'd2, 8'h80);
        hread(3'd4, s); check("R1 foreign write", s, 8'h00);
        hread(3'd6, s); check("R1 foreign read", s, 8'h00);
        // R9 load and drain in the same cycle
        ec_write(8'h50, 8'h9E);
        wait_ibf(); hwrite(3'd4, 8'h80);
        wait_ibf(); hwrite(3'd0, 8'h07);
        idle(); idle();
        wait_ibf(); hwrite(3'd4, 8'h80);
        wait_ibf(); hwrite(3'd0, 8'h50);
        hread(3'd0, v); check("R9 old byte", v, shadow[8'h07]);
        hread(3'd4, s); check("R9 obf kept", s, 8'h01);
        hread(3'd0, v); check("R9 new byte", v, 8'h9E);
        idle(); idle();
        check("R6 queue empty", 8'(exp_q.size()), 8'h00);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule